// File: doc/BRIEF.md
# External Interrupt Sensitivity Detector

This block watches two independent groups of external interrupt lines and raises one request per group. A 2-bit sensitivity code per group decides what counts as an event: rising edges, falling edges, both, or a combined mode in which a falling edge is latched and a low level also requests for as long as it lasts. The lines arrive already synchronized to `clk`. Each group's request is the OR over all of its lines.

Edges are found by comparing each line with its value one cycle earlier. In the edge modes a detected edge sets a pending flag that holds until software pulses the clear strobe. The two codes are loaded through a shared write strobe, and a load takes effect only while the global interrupt mask input is high. All pins are plain control and status signals with no handshake.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset both codes are 00, both pending flags are clear and every line's history is 1, so with all lines high both requests are low.
- R2: With code 00, a falling edge on any line of the group sets its pending flag, and the request is also high in any cycle in which any line of the group is low.
- R3: With code 01, only a rising edge (history 0, line 1) sets the pending flag; a falling edge has no effect on the request.
- R4: With code 10, only a falling edge (history 1, line 0) sets the pending flag; a line held low gives no request after it is cleared.
- R5: With code 11, both a rising and a falling edge set the pending flag.
- R6: On a clock edge with `sens_we` high, the codes are loaded from `sens0_wdata` and `sens1_wdata` only if `irq_mask` is 1; with `irq_mask` 0 the codes keep their old values.
- R7: A pending flag stays set until a clock edge with `req_clr` high and clears on that edge; the request follows one cycle after that edge.
- R8: An edge detected on the same clock edge as `req_clr` leaves the pending flag set.
- R9: The groups are independent: events on one group's lines and its code never change the other group's request, and an edge on any single line of a group is enough.
- R10: With code 00, `req_clr` does not drop the request while any line of the group is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp0_pins | input | LINES | Synchronized lines of group 0 |
| grp1_pins | input | LINES | Synchronized lines of group 1 |
| sens_we | input | 1 | Write strobe for both sensitivity codes |
| sens0_wdata | input | 2 | New code for group 0 (00 fall+low, 01 rise, 10 fall, 11 both) |
| sens1_wdata | input | 2 | New code for group 1, same encoding |
| irq_mask | input | 1 | Global interrupt mask; 1 allows code writes |
| req_clr | input | 1 | Clears both pending flags |
| req0 | output | 1 | Request of group 0 |
| req1 | output | 1 | Request of group 1 |

## Verification
The hardest case is an edge that lands on the same clock edge as a clear, together with a level request that has to survive that clear. The code cannot be read back, so the only way to see it is through how the request reacts. The stimulus gets there by holding a line low in code 00 across several clear pulses, then changing the lines on exactly the cycle that `req_clr` is high. A behavioural model running in lock step checks every cycle. Rejected writes with the mask low are followed by edges that would only raise a request under the rejected code.

// File: rtl/eis_pkg.sv
package eis_pkg;
  typedef enum logic [1:0] {
    SNS_FALL_LOW = 2'b00,
    SNS_RISE     = 2'b01,
    SNS_FALL     = 2'b10,
    SNS_BOTH     = 2'b11
  } sense_e;

  localparam int NGRP = 2;
endpackage

// File: rtl/eis_cfg_reg.sv
module eis_cfg_reg
  import eis_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   we,
  input  logic   imask,
  input  sense_e wdata,
  output sense_e code
);
  // writes accepted only while interrupts are masked
  always_ff @(posedge clk) begin
    if (!rst_n)             code <= SNS_FALL_LOW;
    else if (we && imask)   code <= wdata;
  end
endmodule

// File: rtl/eis_group_det.sv
module eis_group_det
  import eis_pkg::*;
#(
  parameter int LINES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pins,
  input  sense_e           code,
  input  logic             clr,
  output logic [LINES-1:0] hist_o,
  output logic             req_o
);
  logic [LINES-1:0] hist_q;
  logic [LINES-1:0] rise, fall;
  logic             hit, level, pend_q;

  assign rise = pins & ~hist_q;
  assign fall = ~pins & hist_q;

  always_comb begin
    unique case (code)
      SNS_FALL_LOW: hit = |fall;
      SNS_RISE:     hit = |rise;
      SNS_FALL:     hit = |fall;
      SNS_BOTH:     hit = |(rise | fall);
      default:      hit = 1'b0;
    endcase
  end

  assign level = (code == SNS_FALL_LOW) && (pins != {LINES{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= {LINES{1'b1}};
      pend_q <= 1'b0;
    end else begin
      hist_q <= pins;
      pend_q <= (pend_q & ~clr) | hit;  // a new edge wins over clear
    end
  end

  assign hist_o = hist_q;
  assign req_o  = pend_q | level;
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int LINES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] grp0_pins,
  input  logic [LINES-1:0] grp1_pins,
  input  logic             sens_we,
  input  logic [1:0]       sens0_wdata,
  input  logic [1:0]       sens1_wdata,
  input  logic             irq_mask,
  input  logic             req_clr,
  output logic             req0,
  output logic             req1
);
  logic [LINES-1:0] pins [NGRP];
  logic [LINES-1:0] hist [NGRP];
  logic [1:0]       wd   [NGRP];
  sense_e           code [NGRP];
  logic [NGRP-1:0]  req;

  assign pins[0] = grp0_pins;
  assign pins[1] = grp1_pins;
  assign wd[0]   = sens0_wdata;
  assign wd[1]   = sens1_wdata;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    eis_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (sens_we),
      .imask (irq_mask),
      .wdata (sense_e'(wd[g])),
      .code  (code[g])
    );
    eis_group_det #(.LINES(LINES)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .pins   (pins[g]),
      .code   (code[g]),
      .clr    (req_clr),
      .hist_o (hist[g]),
      .req_o  (req[g])
    );
  end

  assign req0 = req[0];
  assign req1 = req[1];
endmodule

// File: rtl/eis_chk.sv
module eis_chk #(
  parameter int LINES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             we,
  input logic             imask,
  input logic             clr,
  input logic [1:0]       code,
  input logic [LINES-1:0] pins,
  input logic [LINES-1:0] hist,
  input logic             req
);
  AST_WRITE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !imask) |=> $stable(code)); // R6
  AST_LEVEL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 2'b00 && pins != {LINES{1'b1}}) |-> req); // R2
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 2'b01 && |(pins & ~hist)) |=> req); // R3
  AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 2'b10 && |(~pins & hist)) |=> req); // R4
  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !clr && code != 2'b00) |=> req); // R7
  AST_CLR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && code == 2'b11 && pins != hist) |=> req); // R8
endmodule

bind ext_irq_sense eis_chk #(.LINES(LINES)) u_chk0 (
  .clk(clk), .rst_n(rst_n), .we(sens_we), .imask(irq_mask), .clr(req_clr),
  .code(code[0]), .pins(grp0_pins), .hist(hist[0]), .req(req0));

bind ext_irq_sense eis_chk #(.LINES(LINES)) u_chk1 (
  .clk(clk), .rst_n(rst_n), .we(sens_we), .imask(irq_mask), .clr(req_clr),
  .code(code[1]), .pins(grp1_pins), .hist(hist[1]), .req(req1));

// File: tb/test_ext_irq_sense.sv
`timescale 1ns/1ps
module test_ext_irq_sense;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins [2];
  logic [1:0] wd [2];
  logic       we = 1'b0, imask = 1'b0, clr = 1'b0;
  logic       req0, req1;
  int         n_tests = 0, n_fail = 0;
  string      phase = "R1";
  bit         done = 1'b0;

  // behavioural reference state
  bit [3:0] m_hist [2];
  bit       m_pend [2];
  bit [1:0] m_code [2];

  always #2.5 clk = ~clk;

  ext_irq_sense #(.LINES(4)) i_ext_irq_sense (
    .clk(clk), .rst_n(rst_n), .grp0_pins(pins[0]), .grp1_pins(pins[1]),
    .sens_we(we), .sens0_wdata(wd[0]), .sens1_wdata(wd[1]),
    .irq_mask(imask), .req_clr(clr), .req0(req0), .req1(req1));

  always @(posedge clk) begin
    for (int g = 0; g < 2; g++) begin
      bit [3:0] r, f;
      bit hit;
      if (!rst_n) begin
        m_hist[g] <= 4'hF; m_pend[g] <= 1'b0; m_code[g] <= 2'b00;
      end else begin
        r = pins[g] & ~m_hist[g];
        f = ~pins[g] & m_hist[g];
        case (m_code[g])
          2'b01:   hit = |r;
          2'b11:   hit = |(r | f);
          default: hit = |f;
        endcase
        m_pend[g] <= (m_pend[g] && !clr) || hit;
        m_hist[g] <= pins[g];
        if (we && imask) m_code[g] <= wd[g];
      end
    end
  end

  function automatic bit exp_req(int g);
    return m_pend[g] || (m_code[g] == 2'b00 && pins[g] != 4'hF);
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int g = 0; g < 2; g++) begin
        logic act;
        act = (g == 0) ? req0 : req1;
        n_tests++;
        if (act !== exp_req(g)) begin
          n_fail++;
          $display("FAIL %s group%0d req actual=%b expected=%b t=%0t",
                   phase, g, act, exp_req(g), $time);
        end
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(bit [1:0] a, bit [1:0] b, bit m);
    wd[0] = a; wd[1] = b; imask = m; we = 1'b1;
    cyc(1);
    we = 1'b0; imask = 1'b0;
  endtask

  task automatic pulse_clr();
    clr = 1'b1; cyc(1); clr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    pins[0] = 4'hF; pins[1] = 4'hF; wd[0] = 2'b00; wd[1] = 2'b00;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    n_tests++;  // R1 explicit reset state
    if (req0 !== 1'b0 || req1 !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset req actual=%b%b expected=00", req0, req1);
    end
    @(posedge clk); #1;
    phase = "R1"; cyc(3);

    // R2 / R10: code 00, level plus latched falling edge
    phase = "R2"; pins[0] = 4'b1101; cyc(3);
    phase = "R10"; pulse_clr(); pulse_clr(); cyc(2);
    phase = "R2"; pins[0] = 4'hF; cyc(2); pulse_clr(); cyc(2);
    phase = "R9"; pins[1] = 4'b0111; cyc(2); pins[1] = 4'hF; pulse_clr(); cyc(2);

    // R6: rejected write, group0 must still behave as code 00
    phase = "R6"; wr(2'b01, 2'b01, 1'b0); cyc(1);
    pins[0] = 4'b1110; cyc(2); pins[0] = 4'hF; pulse_clr(); cyc(2);
    wr(2'b01, 2'b10, 1'b1); cyc(1);

    // R3: rise only on group0
    phase = "R3"; pins[0] = 4'b1011; cyc(3); pins[0] = 4'hF; cyc(3);
    phase = "R7"; cyc(4); pulse_clr(); cyc(2);

    // R4: fall only on group1, held low then cleared
    phase = "R4"; pins[1] = 4'b1110; cyc(3); pulse_clr(); cyc(3);
    pins[1] = 4'hF; cyc(3);

    // R9: edges on group0 lines with group1 in fall mode
    phase = "R9"; pins[0] = 4'b0000; cyc(2); pins[0] = 4'b1000; cyc(2);
    pins[0] = 4'hF; pulse_clr(); cyc(2);

    // R5: both edges
    phase = "R5"; wr(2'b11, 2'b11, 1'b1); cyc(1);
    pins[0] = 4'b0111; cyc(2); pulse_clr(); cyc(2);
    pins[0] = 4'hF; cyc(2); pulse_clr(); cyc(2);
    pins[1] = 4'b1011; cyc(2); pulse_clr(); pins[1] = 4'hF; cyc(2);

    // R8: edge on the same edge as clear
    phase = "R8"; pins[0] = 4'b1101; clr = 1'b1; cyc(1); clr = 1'b0; cyc(3);
    pins[0] = 4'hF; clr = 1'b1; cyc(1); clr = 1'b0; cyc(3);
    pulse_clr(); cyc(2);

    // R10: back to code 00, clear coinciding with falling edge and low level
    phase = "R10"; wr(2'b00, 2'b10, 1'b1); cyc(1);
    pins[0] = 4'b0110; clr = 1'b1; cyc(1); clr = 1'b0; cyc(2);
    pulse_clr(); pins[0] = 4'hF; cyc(2); pulse_clr(); cyc(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule